// File: doc/BRIEF.md
# SD Host Interrupt and Response Register File

This block holds the interrupt and response state of an SD host controller behind a 16-bit register bus with halfword addresses. It keeps a 32-bit interrupt status word and its mask, a 128-bit response buffer, a stop-action register, a port-select register, an option register and a soft-reset register. Internal logic raises status bits through one-cycle set pulses. The card side delivers 32-bit response words, and each word shifts the buffer up by one word.

Software clears status bits by writing zeros. A write of 1 leaves a bit unchanged. The block drives a registered level interrupt and a one-cycle pulse that marks the moment the set of unmasked active bits stops being empty. The low status halfword also reports whether a card is inserted. Clearing bit 0 of the soft-reset register, after it was 1, resets the status, the response buffer, the stop-action register and the option register.

Top module: `sdh_irq_regs`

## Requirements
- R1: After `rst` the mask reads 0x031D (address 12) and 0x8B7F (address 13). The status reads as zero apart from the card bits. The soft-reset register (address 15) reads 0x0007. Port select (address 1) reads 0x0200. The option register (address 14) and stop-action (address 0) read 0. `irq` and `irq_pulse` are low.
- R2: A write to status low (address 10) or status high (address 11) ANDs that half of the status with the written value, so a 0 clears a bit and a 1 leaves it unchanged.
- R3: A read of status low returns the implemented status bits (mask 0x031D) ORed with 0x00B0 when `card_present` is 1, or with 0x0008 when it is 0. A read of status high returns the status bits 31:16.
- R4: A 1 on `irq_set[k]` sets status bit k only when k is an implemented bit (0x8B7F031D). In the same cycle a set beats a clearing write.
- R5: `irq` is high exactly when some status bit is active and unmasked. `irq_pulse` is high for one cycle when a status or mask change makes that set go from empty to non-empty.
- R6: Each `resp_valid` cycle moves response word n to word n+1 and loads `resp_word` into word 0. Halfword k of the buffer reads at address 2+k; word 0 is halfwords 0 (low) and 1 (high).
- R7: A response word with `resp_last` high sets status bit 0.
- R8: A write to address 15 with bit 0 = 0, while the stored bit 0 is 1, is a soft reset. It clears the status, the response buffer and stop-action, and loads the option register with 0x40EE. Input set pulses and response words of that cycle are dropped. Writing 0 while the stored bit is already 0 has no effect. Bits 2:1 of the register always read 1.
- R9: Stop-action keeps only written bits 8 and 0. Port select stores written bits 0x040F and keeps its own bits 9:8. The option register keeps written bits 0xC1FF.
- R10: Mask writes keep only implemented bits. Reads of addresses 16 and above return 0. `rdata` is registered and shows the state at the clock edge where `addr` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Register write strobe |
| addr | input | ADDR_W | Halfword register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq_set | input | 32 | Status set pulses from internal logic |
| resp_valid | input | 1 | Response word strobe |
| resp_word | input | 32 | Response word from the card side |
| resp_last | input | 1 | Marks the final word of a response |
| card_present | input | 1 | Card inserted |
| irq | output | 1 | Level interrupt |
| irq_pulse | output | 1 | One-cycle edge of the interrupt |

## Verification
A wrong status or mask bit shows on `irq` in the cycle after the edge that caused it. It also shows in the next status read. A missing or extra `irq_pulse` reveals an edge detector that compares against the wrong previous level. A mistake in the shift order of the response buffer only shows once several words have arrived, so the bench pushes five words and reads back all eight halfwords. Soft-reset faults show as a stale option value or surviving status. The bench checks them by writing 0 twice, so the falling-edge rule and the level rule give different results.

// File: rtl/sdh_regs_pkg.sv
package sdh_regs_pkg;
  localparam int HW_W       = 16;
  localparam int WORD_W     = 32;
  localparam logic [31:0] STAT_IMPL  = 32'h8B7F_031D;
  localparam logic [15:0] CARD_IN    = 16'h00B0;
  localparam logic [15:0] CARD_OUT   = 16'h0008;
  localparam logic [15:0] STOP_KEEP  = 16'h0101;
  localparam logic [15:0] PORT_WKEEP = 16'h040F;
  localparam logic [15:0] PORT_HOLD  = 16'h0300;
  localparam logic [15:0] OPT_KEEP   = 16'hC1FF;
  localparam logic [15:0] OPT_SRST   = 16'h40EE;
  localparam logic [15:0] SRST_FIXED = 16'h0006;
  localparam int A_STOP     = 0;
  localparam int A_PORT     = 1;
  localparam int A_RESP     = 2;
endpackage

// File: rtl/sdh_resp_buf.sv
module sdh_resp_buf #(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  localparam int TOT_W = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [WORD_W-1:0] word,
  output logic [TOT_W-1:0]  buf_flat
);
  logic [WORD_W-1:0] slot [WORDS];

  generate
    for (genvar i = 0; i < WORDS; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          slot[i] <= '0;
        end else if (push) begin
          if (i == 0) slot[i] <= word;
          else        slot[i] <= slot[(i == 0) ? 0 : i-1];
        end
      end
      assign buf_flat[i*WORD_W +: WORD_W] = slot[i];
    end
  endgenerate

  // R6
  resp_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !clr) |=> (buf_flat[WORD_W-1:0] == $past(word)));

  generate
    if (WORDS > 1) begin : g_shift_chk
      // R6
      resp_move_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !clr) |=> (buf_flat[2*WORD_W-1:WORD_W] == $past(buf_flat[WORD_W-1:0])));
    end
  endgenerate
endmodule

// File: rtl/sdh_irq_ctrl.sv
module sdh_irq_ctrl
  import sdh_regs_pkg::*;
#(
  parameter logic [31:0] IMPL = STAT_IMPL
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        soft_rst,
  input  logic        wr_stat_lo,
  input  logic        wr_stat_hi,
  input  logic        wr_mask_lo,
  input  logic        wr_mask_hi,
  input  logic [15:0] wdata,
  input  logic [31:0] set_vec,
  output logic [31:0] status,
  output logic [31:0] mask,
  output logic        irq,
  output logic        irq_pulse
);
  logic [31:0] keep_vec;
  logic [31:0] status_n;
  logic [31:0] mask_n;
  logic        active_n;

  always_comb begin
    keep_vec = {wr_stat_hi ? wdata : 16'hFFFF, wr_stat_lo ? wdata : 16'hFFFF};
    if (soft_rst) status_n = '0;
    else          status_n = (status & keep_vec) | (set_vec & IMPL);
    mask_n = mask;
    if (wr_mask_lo) mask_n[15:0]  = wdata & IMPL[15:0];
    if (wr_mask_hi) mask_n[31:16] = wdata & IMPL[31:16];
    active_n = |(status_n & ~mask_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status    <= '0;
      mask      <= IMPL;
      irq       <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      status    <= status_n;
      mask      <= mask_n;
      irq       <= active_n;
      irq_pulse <= active_n & ~irq;
    end
  end

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!soft_rst && |(set_vec & IMPL)) |=> ((status & $past(set_vec & IMPL)) == $past(set_vec & IMPL)));

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (irq && !$past(irq)));
endmodule

// File: rtl/sdh_ctl_regs.sv
module sdh_ctl_regs
  import sdh_regs_pkg::*;
#(
  parameter logic [15:0] PORT_RST = 16'h0200
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_stop,
  input  logic        wr_port,
  input  logic        wr_opt,
  input  logic        wr_srst,
  input  logic [15:0] wdata,
  output logic [15:0] stop_q,
  output logic [15:0] port_q,
  output logic [15:0] opt_q,
  output logic [15:0] srst_q,
  output logic        soft_rst
);
  logic srst_bit;

  assign soft_rst = wr_srst & srst_bit & ~wdata[0];
  assign srst_q   = SRST_FIXED | {15'd0, srst_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q   <= '0;
      port_q   <= PORT_RST;
      opt_q    <= '0;
      srst_bit <= 1'b1;
    end else begin
      if (soft_rst)     stop_q <= '0;
      else if (wr_stop) stop_q <= wdata & STOP_KEEP;
      if (wr_port) port_q <= (wdata & PORT_WKEEP) | (port_q & PORT_HOLD);
      if (soft_rst)    opt_q <= OPT_SRST;
      else if (wr_opt) opt_q <= wdata & OPT_KEEP;
      if (wr_srst) srst_bit <= wdata[0];
    end
  end

  // R8
  soft_opt_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (opt_q == OPT_SRST && stop_q == 16'd0));
endmodule

// File: rtl/sdh_irq_regs.sv
module sdh_irq_regs
  import sdh_regs_pkg::*;
#(
  parameter int          ADDR_W     = 5,
  parameter int          RESP_WORDS = 4,
  parameter logic [15:0] PORT_RST   = 16'h0200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  input  logic [31:0]       irq_set,
  input  logic              resp_valid,
  input  logic [31:0]       resp_word,
  input  logic              resp_last,
  input  logic              card_present,
  output logic              irq,
  output logic              irq_pulse
);
  localparam int RESP_HW = 2 * RESP_WORDS;
  localparam int A_STLO  = A_RESP + RESP_HW;
  localparam int A_STHI  = A_STLO + 1;
  localparam int A_MKLO  = A_STLO + 2;
  localparam int A_MKHI  = A_STLO + 3;
  localparam int A_OPT   = A_STLO + 4;
  localparam int A_SRST  = A_STLO + 5;

  logic [RESP_WORDS*WORD_W-1:0] resp_flat;
  logic [31:0] status, mask, set_vec;
  logic [15:0] stop_q, port_q, opt_q, srst_q;
  logic        soft_rst;
  logic        wr_stop, wr_port, wr_opt, wr_srst;
  logic        wr_stlo, wr_sthi, wr_mklo, wr_mkhi;
  logic [15:0] rd_n;

  assign wr_stop = we && (addr == ADDR_W'(A_STOP));
  assign wr_port = we && (addr == ADDR_W'(A_PORT));
  assign wr_stlo = we && (addr == ADDR_W'(A_STLO));
  assign wr_sthi = we && (addr == ADDR_W'(A_STHI));
  assign wr_mklo = we && (addr == ADDR_W'(A_MKLO));
  assign wr_mkhi = we && (addr == ADDR_W'(A_MKHI));
  assign wr_opt  = we && (addr == ADDR_W'(A_OPT));
  assign wr_srst = we && (addr == ADDR_W'(A_SRST));

  assign set_vec = irq_set | {31'd0, resp_valid & resp_last};

  sdh_ctl_regs #(.PORT_RST(PORT_RST)) u_ctl (
    .clk(clk), .rst(rst),
    .wr_stop(wr_stop), .wr_port(wr_port), .wr_opt(wr_opt), .wr_srst(wr_srst),
    .wdata(wdata),
    .stop_q(stop_q), .port_q(port_q), .opt_q(opt_q), .srst_q(srst_q),
    .soft_rst(soft_rst)
  );

  sdh_irq_ctrl #(.IMPL(STAT_IMPL)) u_irq (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .wr_stat_lo(wr_stlo), .wr_stat_hi(wr_sthi),
    .wr_mask_lo(wr_mklo), .wr_mask_hi(wr_mkhi),
    .wdata(wdata), .set_vec(set_vec),
    .status(status), .mask(mask), .irq(irq), .irq_pulse(irq_pulse)
  );

  sdh_resp_buf #(.WORDS(RESP_WORDS), .WORD_W(WORD_W)) u_resp (
    .clk(clk), .rst(rst), .clr(soft_rst),
    .push(resp_valid), .word(resp_word),
    .buf_flat(resp_flat)
  );

  always_comb begin
    rd_n = '0;
    for (int k = 0; k < RESP_HW; k++) begin
      if (addr == ADDR_W'(A_RESP + k)) rd_n = resp_flat[k*HW_W +: HW_W];
    end
    if (addr == ADDR_W'(A_STOP)) rd_n = stop_q;
    if (addr == ADDR_W'(A_PORT)) rd_n = port_q;
    if (addr == ADDR_W'(A_STLO))
      rd_n = (status[15:0] & STAT_IMPL[15:0]) | (card_present ? CARD_IN : CARD_OUT);
    if (addr == ADDR_W'(A_STHI)) rd_n = status[31:16];
    if (addr == ADDR_W'(A_MKLO)) rd_n = mask[15:0];
    if (addr == ADDR_W'(A_MKHI)) rd_n = mask[31:16];
    if (addr == ADDR_W'(A_OPT))  rd_n = opt_q;
    if (addr == ADDR_W'(A_SRST)) rd_n = srst_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end

  // R7
  last_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_last && !soft_rst) |=> status[0]);

  // R8
  soft_clr_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (status == 32'd0 && resp_flat == '0));

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (status & ~mask) == 32'd0 |-> !irq);
endmodule

// File: tb/tb_sdh_irq_regs.sv
module tb_sdh_irq_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [31:0] irq_set = '0;
  logic        resp_valid = 1'b0;
  logic [31:0] resp_word = '0;
  logic        resp_last = 1'b0;
  logic        card_present = 1'b0;
  logic        irq, irq_pulse;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdh_irq_regs #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_set(irq_set), .resp_valid(resp_valid), .resp_word(resp_word),
    .resp_last(resp_last), .card_present(card_present),
    .irq(irq), .irq_pulse(irq_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [15:0] exp, input string tag);
    @(negedge clk); we = 1'b0; addr = AW'(a);
    @(posedge clk); #1;
    chk(tag, {16'd0, rdata}, {16'd0, exp});
  endtask

  task automatic pulse_set(input logic [31:0] v);
    @(negedge clk); irq_set = v;
    @(negedge clk); irq_set = '0;
  endtask

  task automatic push(input logic [31:0] w, input logic last);
    @(negedge clk); resp_valid = 1'b1; resp_word = w; resp_last = last;
    @(negedge clk); resp_valid = 1'b0; resp_last = 1'b0;
  endtask

  task automatic t_reset;
    card_present = 1'b0;
    rd(12, 16'h031D, "R1 mask lo");
    rd(13, 16'h8B7F, "R1 mask hi");
    rd(10, 16'h0008, "R1/R3 status lo no card");
    rd(11, 16'h0000, "R1 status hi");
    rd(15, 16'h0007, "R1 soft reset reg");
    rd(1,  16'h0200, "R1 port select");
    rd(14, 16'h0000, "R1 option");
    rd(0,  16'h0000, "R1 stop action");
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    chk("R1 irq_pulse low", {31'd0, irq_pulse}, 32'd0);
  endtask

  task automatic t_set_clear;
    pulse_set(32'hFFFF_FFFF);
    card_present = 1'b1;
    rd(10, 16'h03BD, "R3/R4 status lo with card");
    rd(11, 16'h8B7F, "R4 status hi implemented only");
    chk("R5 irq masked", {31'd0, irq}, 32'd0);
    card_present = 1'b0;
    wr(10, 16'hFFFE);
    rd(10, 16'h031C, "R2 clear bit0 lo");
    wr(11, 16'h7FFF);
    rd(11, 16'h0B7F, "R2 clear bit31 hi");
    wr(10, 16'h0000);
    wr(11, 16'h0000);
    rd(10, 16'h0008, "R2 all cleared lo");
    // R4: set beats clear in same cycle
    pulse_set(32'h0000_0010);
    @(negedge clk); we = 1'b1; addr = AW'(10); wdata = 16'h0000; irq_set = 32'h0000_0100;
    @(negedge clk); we = 1'b0; irq_set = '0;
    rd(10, 16'h0108, "R4 set beats clear");
    wr(10, 16'h0000);
  endtask

  task automatic t_irq;
    wr(12, 16'h0000);
    chk("R5 no status no irq", {31'd0, irq}, 32'd0);
    @(negedge clk); irq_set = 32'h4;
    @(negedge clk); irq_set = '0;
    chk("R5 irq after set", {31'd0, irq}, 32'd1);
    chk("R5 pulse after set", {31'd0, irq_pulse}, 32'd1);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'd0, irq_pulse}, 32'd0);
    chk("R5 irq held", {31'd0, irq}, 32'd1);
    @(negedge clk); irq_set = 32'h8;
    @(negedge clk); irq_set = '0;
    chk("R5 no pulse when already active", {31'd0, irq_pulse}, 32'd0);
    wr(10, 16'h0000);
    chk("R5 irq drops after clear", {31'd0, irq}, 32'd0);
    wr(12, 16'h031D);
    pulse_set(32'h10);
    chk("R5 masked bit no irq", {31'd0, irq}, 32'd0);
    @(negedge clk); we = 1'b1; addr = AW'(12); wdata = 16'h0000;
    @(negedge clk); we = 1'b0;
    chk("R5 unmask pulse", {31'd0, irq_pulse}, 32'd1);
    chk("R5 unmask level", {31'd0, irq}, 32'd1);
    wr(10, 16'h0000);
    wr(12, 16'hFFFF);
    rd(12, 16'h031D, "R10 mask keeps implemented bits");
  endtask

  task automatic t_resp;
    push(32'hA1A0_A3A2, 1'b0);
    push(32'hB1B0_B3B2, 1'b0);
    push(32'hC1C0_C3C2, 1'b0);
    push(32'hD1D0_D3D2, 1'b0);
    rd(10, 16'h0008, "R7 no last no bit0");
    push(32'hE1E0_E3E2, 1'b1);
    rd(2, 16'hE3E2, "R6 hw0");
    rd(3, 16'hE1E0, "R6 hw1");
    rd(4, 16'hD3D2, "R6 hw2");
    rd(5, 16'hD1D0, "R6 hw3");
    rd(6, 16'hC3C2, "R6 hw4");
    rd(7, 16'hC1C0, "R6 hw5");
    rd(8, 16'hB3B2, "R6 hw6");
    rd(9, 16'hB1B0, "R6 hw7");
    rd(10, 16'h0009, "R7 last sets bit0");
  endtask

  task automatic t_misc;
    wr(0, 16'hFFFF);
    rd(0, 16'h0101, "R9 stop keeps 8 and 0");
    wr(1, 16'hFFFF);
    rd(1, 16'h060F, "R9 port select");
    wr(14, 16'hFFFF);
    rd(14, 16'hC1FF, "R9 option");
    wr(20, 16'hFFFF);
    rd(20, 16'h0000, "R10 unimplemented read");
    rd(31, 16'h0000, "R10 top address read");
  endtask

  task automatic t_soft;
    pulse_set(32'h0100_0000);
    wr(15, 16'h0000);
    rd(10, 16'h0008, "R8 status lo cleared");
    rd(11, 16'h0000, "R8 status hi cleared");
    rd(2, 16'h0000, "R8 resp cleared");
    rd(9, 16'h0000, "R8 resp top cleared");
    rd(0, 16'h0000, "R8 stop cleared");
    rd(14, 16'h40EE, "R8 option loaded");
    rd(15, 16'h0006, "R8 fixed bits read 1");
    rd(1, 16'h060F, "R8 port untouched");
    wr(14, 16'h0001);
    wr(15, 16'h0000);
    rd(14, 16'h0001, "R8 no reset when bit already 0");
    wr(15, 16'h0001);
    rd(15, 16'h0007, "R8 bit0 set");
    wr(15, 16'h0000);
    rd(14, 16'h40EE, "R8 second falling edge");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set_clear();
    t_irq();
    t_resp();
    t_misc();
    t_soft();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule